// File: doc/BRIEF.md
# Configuration Port Gate with Banked Logical Devices

This block is the configuration front end of a multi-function peripheral controller. It sits on an 8-bit I/O bus and answers at two addresses: an index port at `BASE_ADDR` and a data port at `BASE_ADDR + 1`. Configuration access stays locked until the unlock byte 0x87 is written to the index port on two consecutive writes. While the gate is open, a write to the index port names a register, and a data-port write stores a byte into that register. A data-port read returns the register's contents. Writing 0xAA to the index port locks the gate again.

Indices 0x00 to 0x2F form a global register space that is shared by all devices. Index 0x07 holds the logical-device number. Indices 0x30 to 0x7F are banked: each logical device has its own copy, and the device number picks which copy is accessed. For each device the block presents its activate bit, its 16-bit base address, its interrupt number and its interrupt type as parallel outputs, so that the functional units can use them directly.

Top module: `cfg_gate_top`

## Requirements
- R1: After reset the gate is closed, data-port reads return 0xFF, every device is inactive, and every stored register (global and banked) is 0x00.
- R2: Two consecutive index-port writes of 0x87 open the gate.
- R3: While one 0x87 has been seen, any other index byte or any data-port write returns the gate to fully closed. A single further 0x87 then leaves it still closed.
- R4: An index-port write of 0xAA while open closes the gate. While closed, index and data writes change no register and no output, and data-port reads return 0xFF.
- R5: While open, a data-port write stores the byte into the register last named on the index port. A data-port read returns that register combinationally.
- R6: Indices 0x00–0x2F are global and read back the same value for every device number. Index 0x07 holds the device number and reads back what was written.
- R7: Indices 0x30–0x7F are banked per device number (0 to NUM_DEV-1). If the device number is NUM_DEV or above, banked writes are dropped and banked reads return 0x00. Indices 0x80–0xFF ignore writes and read 0x00.
- R8: `dev_en_o[d]` equals bit 0 of banked index 0x30 of device d.
- R9: `dev_base_o` slice d is {index 0x60, index 0x61} of device d, high byte first.
- R10: `dev_irq_o` slice d is banked index 0x70 and `dev_irq_type_o` slice d is banked index 0x71 of device d (0x02 meaning active-high, edge).
- R11: Writes to any address other than the two ports have no effect, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | I/O address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current address |
| dev_en_o | output | NUM_DEV | Per-device activate bit |
| dev_base_o | output | NUM_DEV*16 | Per-device base address |
| dev_irq_o | output | NUM_DEV*8 | Per-device interrupt number |
| dev_irq_type_o | output | NUM_DEV*8 | Per-device interrupt type |

## Verification
The assertions check the unlock sequence on every cycle. A second 0x87 opens the gate, any other byte in the half-open state resets it, and 0xAA closes it. They also check on every cycle that nothing moves on the device outputs while the gate is closed or when the bus writes to a foreign address. Only the bench scenarios can show the storage side. That covers register values that persist through a close and reopen, the separation of global registers from banked ones, the dropping of writes when the device number is out of range, and the correct byte order of the base address.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  typedef enum logic [1:0] {
    GATE_SHUT = 2'd0,
    GATE_HALF = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;

  localparam logic [7:0] KEY_ENTER    = 8'h87;
  localparam logic [7:0] KEY_EXIT     = 8'hAA;
  localparam logic [7:0] IDX_LDN      = 8'h07;
  localparam logic [7:0] IDX_BANK_LO  = 8'h30;
  localparam logic [7:0] IDX_ACT      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
  localparam logic [7:0] IDX_IRQ      = 8'h70;
  localparam logic [7:0] IDX_IRQ_TYPE = 8'h71;
  localparam logic [7:0] RD_IDLE      = 8'hFF;
endpackage

// File: rtl/cfg_gate_fsm.sv
module cfg_gate_fsm
  import cfg_gate_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       data_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o,
  output logic       half_o,
  output logic [7:0] idx_o,
  output logic       cfg_wr_o
);
  gate_state_e state_q, state_d;
  logic [7:0]  idx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_SHUT: if (idx_wr_i && wdata_i == KEY_ENTER) state_d = GATE_HALF;
      GATE_HALF: begin
        if (idx_wr_i) state_d = (wdata_i == KEY_ENTER) ? GATE_OPEN : GATE_SHUT;
        else if (data_wr_i) state_d = GATE_SHUT;
      end
      GATE_OPEN: if (idx_wr_i && wdata_i == KEY_EXIT) state_d = GATE_SHUT;
      default:   state_d = GATE_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_SHUT;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == GATE_OPEN && idx_wr_i && wdata_i != KEY_EXIT) idx_q <= wdata_i;
    end
  end

  assign open_o   = (state_q == GATE_OPEN);
  assign half_o   = (state_q == GATE_HALF);
  assign idx_o    = idx_q;
  assign cfg_wr_o = open_o && data_wr_i;
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_gate_pkg::*;
#(
  parameter int GLOBAL_N = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ldn_o,
  output logic [7:0] rdata_o
);
  localparam int GIDX_W = $clog2(GLOBAL_N);

  logic [7:0]        regs_q [GLOBAL_N];
  logic              hit;
  logic [GIDX_W-1:0] sel;

  assign hit = ({24'd0, idx_i} < GLOBAL_N);
  assign sel = idx_i[GIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < GLOBAL_N; i++) regs_q[i] <= '0;
    end else if (wr_i && hit) begin
      regs_q[sel] <= wdata_i;
    end
  end

  assign ldn_o   = regs_q[IDX_LDN[GIDX_W-1:0]];
  assign rdata_o = hit ? regs_q[sel] : 8'h00;
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_gate_pkg::*;
#(
  parameter int BANK_N = 80
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        act_o,
  output logic [15:0] base_o,
  output logic [7:0]  irq_o,
  output logic [7:0]  irq_type_o
);
  localparam int BIDX_W  = $clog2(BANK_N);
  localparam int OFF_ACT = int'(IDX_ACT - IDX_BANK_LO);
  localparam int OFF_BHI = int'(IDX_BASE_HI - IDX_BANK_LO);
  localparam int OFF_BLO = int'(IDX_BASE_LO - IDX_BANK_LO);
  localparam int OFF_IRQ = int'(IDX_IRQ - IDX_BANK_LO);
  localparam int OFF_ITY = int'(IDX_IRQ_TYPE - IDX_BANK_LO);

  logic [7:0]        regs_q [BANK_N];
  logic [7:0]        off;
  logic              hit;
  logic [BIDX_W-1:0] sel;

  assign off = idx_i - IDX_BANK_LO;
  assign hit = (idx_i >= IDX_BANK_LO) && ({24'd0, off} < BANK_N);
  assign sel = off[BIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BANK_N; i++) regs_q[i] <= '0;
    end else if (wr_i && hit) begin
      regs_q[sel] <= wdata_i;
    end
  end

  assign rdata_o    = hit ? regs_q[sel] : 8'h00;
  assign act_o      = regs_q[OFF_ACT][0];
  assign base_o     = {regs_q[OFF_BHI], regs_q[OFF_BLO]};
  assign irq_o      = regs_q[OFF_IRQ];
  assign irq_type_o = regs_q[OFF_ITY];
endmodule

// File: rtl/cfg_gate_top.sv
module cfg_gate_top
  import cfg_gate_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0370,
  parameter int              NUM_DEV   = 9,
  parameter int              BANK_N    = 80
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  output logic [NUM_DEV-1:0]     dev_en_o,
  output logic [NUM_DEV*16-1:0]  dev_base_o,
  output logic [NUM_DEV*8-1:0]   dev_irq_o,
  output logic [NUM_DEV*8-1:0]   dev_irq_type_o
);
  localparam int                GLOBAL_N  = int'(IDX_BANK_LO);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic       idx_hit, data_hit;
  logic       gate_open, gate_half, cfg_wr;
  logic [7:0] cfg_idx, ldn, glob_rd, bank_sel_rd, reg_rd;
  logic [7:0] bank_rd [NUM_DEV];

  assign idx_hit  = (addr_i == BASE_ADDR);
  assign data_hit = (addr_i == DATA_ADDR);

  cfg_gate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_wr_i  (wr_en_i && idx_hit),
    .data_wr_i (wr_en_i && data_hit),
    .wdata_i   (wdata_i),
    .open_o    (gate_open),
    .half_o    (gate_half),
    .idx_o     (cfg_idx),
    .cfg_wr_o  (cfg_wr)
  );

  cfg_global_regs #(.GLOBAL_N(GLOBAL_N)) u_glob (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .idx_i   (cfg_idx),
    .wdata_i (wdata_i),
    .ldn_o   (ldn),
    .rdata_o (glob_rd)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam logic [7:0] DEV_ID = 8'(d);
    cfg_dev_bank #(.BANK_N(BANK_N)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (cfg_wr && ldn == DEV_ID),
      .idx_i      (cfg_idx),
      .wdata_i    (wdata_i),
      .rdata_o    (bank_rd[d]),
      .act_o      (dev_en_o[d]),
      .base_o     (dev_base_o[d*16 +: 16]),
      .irq_o      (dev_irq_o[d*8 +: 8]),
      .irq_type_o (dev_irq_type_o[d*8 +: 8])
    );
  end

  always_comb begin
    bank_sel_rd = 8'h00;
    for (int d = 0; d < NUM_DEV; d++)
      if (ldn == 8'(d)) bank_sel_rd = bank_rd[d];
  end

  assign reg_rd  = (cfg_idx < IDX_BANK_LO) ? glob_rd : bank_sel_rd;
  assign rdata_o = (gate_open && data_hit) ? reg_rd : RD_IDLE;
endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0370,
  parameter int                NUM_DEV   = 9
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [7:0]            wdata_i,
  input logic [7:0]            rdata_o,
  input logic [NUM_DEV-1:0]    dev_en_o,
  input logic [NUM_DEV*16-1:0] dev_base_o,
  input logic                  gate_open,
  input logic                  gate_half
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic idx_w, data_w, foreign_w;
  assign idx_w     = wr_en_i && addr_i == BASE_ADDR;
  assign data_w    = wr_en_i && addr_i == DATA_ADDR;
  assign foreign_w = wr_en_i && !(addr_i == BASE_ADDR) && !(addr_i == DATA_ADDR);

  p_state_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gate_open, gate_half}));

  p_second_key_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_half && idx_w && wdata_i == 8'h87 |=> gate_open);

  p_half_from_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_half) |-> $past(idx_w && wdata_i == 8'h87));

  p_bad_byte_resets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_half && ((idx_w && wdata_i != 8'h87) || data_w) |=> !gate_half && !gate_open);

  p_exit_closes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_open && idx_w && wdata_i == 8'hAA |=> !gate_open && !gate_half);

  p_shut_no_effect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_open && wr_en_i |=> $stable(dev_en_o) && $stable(dev_base_o));

  p_shut_read_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_open && addr_i == DATA_ADDR |-> rdata_o == 8'hFF);

  p_foreign_no_effect_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign_w |=> $stable(dev_en_o) && $stable(dev_base_o));
endmodule

bind cfg_gate_top cfg_gate_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .dev_en_o   (dev_en_o),
  .dev_base_o (dev_base_o),
  .gate_open  (gate_open),
  .gate_half  (gate_half)
);

// File: tb/tb_cfg_gate_top.sv
`timescale 1ns/1ps
module tb_cfg_gate_top;
  localparam int          ADDR_W  = 16;
  localparam logic [15:0] BASE    = 16'h0370;
  localparam logic [15:0] DATA    = 16'h0371;
  localparam int          NUM_DEV = 9;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  wr_en = 1'b0;
  logic [ADDR_W-1:0]     addr = '0;
  logic [7:0]            wdata = '0;
  logic [7:0]            rdata;
  logic [NUM_DEV-1:0]    dev_en;
  logic [NUM_DEV*16-1:0] dev_base;
  logic [NUM_DEV*8-1:0]  dev_irq, dev_irq_type;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int    kind;
    int    dev;
    int    exp;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  cfg_gate_top #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .NUM_DEV(NUM_DEV)) dut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en),
    .addr_i         (addr),
    .wdata_i        (wdata),
    .rdata_o        (rdata),
    .dev_en_o       (dev_en),
    .dev_base_o     (dev_base),
    .dev_irq_o      (dev_irq),
    .dev_irq_type_o (dev_irq_type)
  );

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.kind)
          0: act = int'(rdata);
          1: act = int'(dev_en[it.dev]);
          2: act = int'(dev_base[it.dev*16 +: 16]);
          3: act = int'(dev_irq[it.dev*8 +: 8]);
          default: act = int'(dev_irq_type[it.dev*8 +: 8]);
        endcase
        checks++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d dev=%0d actual=0x%0h expected=0x%0h",
                   it.tag, it.kind, it.dev, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idx(input logic [7:0] d); wr(BASE, d); endtask
  task automatic dat(input logic [7:0] d); wr(DATA, d); endtask
  task automatic setr(input logic [7:0] i, input logic [7:0] d); idx(i); dat(d); endtask

  task automatic push(input int kind, input int dev, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.dev = dev; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_rd(input logic [15:0] a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    push(0, 0, exp, tag);
    wait (q.size() == 0);
  endtask

  task automatic chk_dev(input int kind, input int dev, input int exp, input string tag);
    push(kind, dev, exp, tag);
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk_rd(DATA, 8'hFF, "R1 closed read");
    for (int d = 0; d < NUM_DEV; d++) begin
      chk_dev(1, d, 0, "R1 dev_en");
      chk_dev(2, d, 0, "R1 base");
    end

    // R2 open
    idx(8'h87); idx(8'h87);
    idx(8'h22);
    chk_rd(DATA, 8'h00, "R1 reg zero");
    // R5 write/read
    dat(8'hFE);
    chk_rd(DATA, 8'hFE, "R5 readback");
    chk_rd(DATA, 8'hFE, "R2 gate open");

    // R6 global vs device number
    setr(8'h07, 8'h05);
    chk_rd(DATA, 8'h05, "R6 ldn readback");
    setr(8'h07, 8'h02);
    idx(8'h22);
    chk_rd(DATA, 8'hFE, "R6 global shared");

    // R8 R9 R10 device 5 programming
    setr(8'h07, 8'h05);
    setr(8'h60, 8'h00); setr(8'h61, 8'h60);
    setr(8'h70, 8'h01); setr(8'h71, 8'h02);
    setr(8'h30, 8'h01);
    chk_dev(1, 5, 1, "R8 dev5 active");
    chk_dev(1, 6, 0, "R8 dev6 idle");
    chk_dev(2, 5, 16'h0060, "R9 dev5 base");
    chk_dev(3, 5, 1, "R10 dev5 irq");
    chk_dev(4, 5, 2, "R10 dev5 irq type");

    // R7 banking
    setr(8'h07, 8'h06);
    idx(8'h60);
    chk_rd(DATA, 8'h00, "R7 dev6 own bank");
    dat(8'h01); setr(8'h61, 8'h80);
    chk_dev(2, 6, 16'h0180, "R9 dev6 base");
    chk_dev(2, 5, 16'h0060, "R7 dev5 base kept");
    setr(8'h7F, 8'h3C);
    chk_rd(DATA, 8'h3C, "R7 top banked index");
    setr(8'h80, 8'h55);
    chk_rd(DATA, 8'h00, "R7 index above bank");
    // out-of-range device number
    setr(8'h07, 8'h09);
    setr(8'h30, 8'h01);
    chk_rd(DATA, 8'h00, "R7 ldn out of range read");
    for (int d = 0; d < NUM_DEV; d++)
      chk_dev(1, d, (d == 5) ? 1 : 0, "R7 ldn out of range write");

    // R8 bit 0 only
    setr(8'h07, 8'h05);
    setr(8'h30, 8'h00);
    chk_dev(1, 5, 0, "R8 dev5 disabled");
    dat(8'h03);
    chk_dev(1, 5, 1, "R8 bit0 enable");
    chk_rd(DATA, 8'h03, "R8 full byte stored");

    // R11 foreign address
    idx(8'h22);
    wr(16'h0372, 8'h11);
    wr(16'h036F, 8'h11);
    chk_rd(DATA, 8'hFE, "R11 foreign write ignored");
    chk_rd(16'h0372, 8'hFF, "R11 foreign read");

    // R4 close, writes ignored
    idx(8'h30);
    idx(8'hAA);
    chk_rd(DATA, 8'hFF, "R4 closed read");
    dat(8'h00);
    chk_dev(1, 5, 1, "R4 closed data write ignored");
    idx(8'h22); dat(8'h99);
    idx(8'h87); idx(8'h87);
    idx(8'h22);
    chk_rd(DATA, 8'hFE, "R4 closed write left reg");
    idx(8'hAA);

    // R3 broken key sequences
    idx(8'h87); idx(8'h12); idx(8'h87);
    chk_rd(DATA, 8'hFF, "R3 other index byte");
    dat(8'h00);
    idx(8'h87);
    chk_rd(DATA, 8'hFF, "R3 data write breaks key");
    idx(8'h87);
    idx(8'h22);
    chk_rd(DATA, 8'hFE, "R2 reopen after key");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule